// File: doc/BRIEF.md
# Sync Conditioning and Clamp Pulse Generator

This block sits between the raw synchronisation inputs of a video capture front end and the rest of the pipeline. It brings horizontal sync, horizontal flyback, vertical sync and an external clamp signal into the pixel-clock domain through two-flop synchronisers. It converts each one to an active-high internal form using programmable polarities. A select bit decides whether horizontal sync or horizontal flyback serves as the horizontal timing reference.

From the conditioned signals it drives a combined blank/interrupt pin. The pin has three modes and a programmable output polarity. A clamp pulse is generated a programmable number of two-clock steps after each leading edge of the horizontal reference. The clamp pin can either drive that pulse out or accept an external clamp. A force-black control replaces the outgoing video word with a fixed black code.

Configuration uses a small write-only register bus with a 2-bit address and 8-bit data.
- Address 0: bit 0 horizontal polarity, bit 1 vertical polarity, bit 2 reference select, bit 3 force black.
- Address 1: bits 1:0 blank mode, bit 2 blank polarity, bit 3 clamp direction, bit 4 clamp polarity.
- Address 2: clamp position bits 7:0.
- Address 3: clamp position bits 9:8, in data bits 1:0.

Top module: `sync_clamp_gen`

## Requirements
- R1: While reset is held, and until the first write, the configuration holds its defaults. Every bit is 0 except blank mode, which is 01. Under these defaults blank_o, clamp_pad_o, clamp_pad_oe_o, clamp_active_o and vid_o are all 0.
- R2: Every raw input is seen through two flops. Address 0 bit 0 inverts the chosen horizontal reference when 1 (active-low input). The normalised reference after clock edge n reflects the raw value sampled at edge n-1.
- R3: Address 0 bit 1 inverts the synchronised vertical sync when 1. When 0, vertical sync is taken as active-high.
- R4: Address 0 bit 2 selects the horizontal reference: 0 takes hsync_i, 1 takes hflyback_i. The polarity of R2 applies to whichever input is selected.
- R5: Blank mode is address 1 bits 1:0. 00 keeps blank inactive. 01 follows the normalised vertical sync. 1x is active when either the normalised horizontal reference or the normalised vertical sync is active.
- R6: Address 1 bit 2 set to 1 makes blank_o active-low. Set to 0, it is active-high.
- R7: Let P be the 10-bit clamp position and let E be the cycle in which a leading edge is seen on the normalised reference. The internal clamp pulse is then high for exactly 8 cycles, from cycle E+1+2P through cycle E+8+2P.
- R8: A new leading edge restarts the clamp timing from that edge, whether a delay or a pulse is in progress. The position used is the one valid when the edge is seen.
- R9: When address 1 bit 3 is 1, the clamp pin drives: clamp_pad_oe_o is 1 and clamp_pad_o carries the pulse, inverted when address 1 bit 4 is 1. When bit 3 is 0, clamp_pad_oe_o is 0.
- R10: clamp_active_o gives the active-high clamp state. In input mode it is the synchronised clamp_pad_i, inverted when address 1 bit 4 is 1. In output mode it is the internal pulse.
- R11: vid_o is registered. After edge n it shows the black code (default 0x10) when force black was 1 before that edge. Otherwise it shows the vid_i sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released in step with clk_i |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| hsync_i | input | 1 | Raw horizontal sync |
| hflyback_i | input | 1 | Raw horizontal flyback |
| vsync_i | input | 1 | Raw vertical sync |
| clamp_pad_i | input | 1 | Clamp pin input path |
| vid_i | input | 8 | Incoming video word |
| vid_o | output | 8 | Video word, or black code when forced |
| blank_o | output | 1 | Blank/interrupt pin |
| clamp_pad_o | output | 1 | Clamp pin output path |
| clamp_pad_oe_o | output | 1 | Clamp pin output enable |
| clamp_active_o | output | 1 | Internal active-high clamp state |

## Verification
The assertions assume reset is released synchronously. They also assume the clamp position and reference select are only rewritten between clamp windows; if they change, the assertions simply check against the value in force at the next leading edge. The raw sync and clamp inputs may change in any cycle, because the synchronisers make them effectively asynchronous. The stimulus toggles those inputs at random, with rates chosen so that edges often land inside a running delay or pulse. All register writes are made between runs, at clock-aligned times away from the sampling point.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

  localparam int unsigned CLAMP_POS_W = 10;

  typedef enum logic [1:0] {
    CLP_IDLE  = 2'd0,
    CLP_WAIT  = 2'd1,
    CLP_PULSE = 2'd2
  } clp_state_e;

  typedef struct packed {
    logic                   hpol;
    logic                   vpol;
    logic                   ref_sel;
    logic                   force_black;
    logic [1:0]             blank_mode;
    logic                   blank_pol;
    logic                   clamp_dir;
    logic                   clamp_pol;
    logic [CLAMP_POS_W-1:0] clamp_pos;
  } sgc_cfg_t;

endpackage

// File: rtl/sgc_cfg_regs.sv
module sgc_cfg_regs
  import sgc_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output sgc_cfg_t          cfg_o
);

  localparam int unsigned POS_HI_W = CLAMP_POS_W - 8;

  sgc_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) begin
      case (addr_i)
        2'd0: begin
          cfg_d.hpol        = wdata_i[0];
          cfg_d.vpol        = wdata_i[1];
          cfg_d.ref_sel     = wdata_i[2];
          cfg_d.force_black = wdata_i[3];
        end
        2'd1: begin
          cfg_d.blank_mode = wdata_i[1:0];
          cfg_d.blank_pol  = wdata_i[2];
          cfg_d.clamp_dir  = wdata_i[3];
          cfg_d.clamp_pol  = wdata_i[4];
        end
        2'd2: cfg_d.clamp_pos[7:0] = wdata_i[7:0];
        default: cfg_d.clamp_pos[CLAMP_POS_W-1:8] = wdata_i[POS_HI_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q            <= '0;
      cfg_q.blank_mode <= 2'b01;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/sgc_sync.sv
module sgc_sync #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] sync_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic st1_q, st2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st1_q <= 1'b0;
        st2_q <= 1'b0;
      end else begin
        st1_q <= raw_i[i];
        st2_q <= st1_q;
      end
    end
    assign sync_o[i] = st2_q;
  end

endmodule

// File: rtl/sgc_clamp_fsm.sv
module sgc_clamp_fsm
  import sgc_pkg::*;
#(
  parameter int unsigned POS_W   = CLAMP_POS_W,
  parameter int unsigned PULSE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lead_edge_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             pulse_o
);

  localparam int unsigned CNT_W = POS_W + 1;
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_W - 1);

  clp_state_e       state_d, state_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (lead_edge_i) begin
      if (pos_i == '0) begin
        state_d = CLP_PULSE;
        cnt_d   = PULSE_LAST;
      end else begin
        state_d = CLP_WAIT;
        cnt_d   = {pos_i, 1'b0} - CNT_W'(1);
      end
    end else begin
      case (state_q)
        CLP_WAIT: begin
          if (cnt_q == '0) begin
            state_d = CLP_PULSE;
            cnt_d   = PULSE_LAST;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        CLP_PULSE: begin
          if (cnt_q == '0) begin
            state_d = CLP_IDLE;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        default: state_d = CLP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CLP_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pulse_o = (state_q == CLP_PULSE);

  a_r7_zero_pos_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_edge_i && pos_i == '0) |=> pulse_o);

  a_r8_edge_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_edge_i |=> (state_q != CLP_IDLE));

  a_r7_pulse_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CLP_PULSE) |-> (cnt_q <= PULSE_LAST));

endmodule

// File: rtl/sync_clamp_gen.sv
module sync_clamp_gen
  import sgc_pkg::*;
#(
  parameter int unsigned VID_W      = 8,
  parameter logic [VID_W-1:0] BLACK_CODE = 8'h10,
  parameter int unsigned PULSE_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [7:0]       cfg_wdata_i,
  input  logic             hsync_i,
  input  logic             hflyback_i,
  input  logic             vsync_i,
  input  logic             clamp_pad_i,
  input  logic [VID_W-1:0] vid_i,
  output logic [VID_W-1:0] vid_o,
  output logic             blank_o,
  output logic             clamp_pad_o,
  output logic             clamp_pad_oe_o,
  output logic             clamp_active_o
);

  localparam int unsigned N_SYNC = 4;

  sgc_cfg_t          cfg;
  logic [N_SYNC-1:0] sync_s;
  logic              href_n, vs_n, ext_clamp_n, href_q, lead_edge;
  logic              blank_act, pulse;
  logic [VID_W-1:0]  vid_d, vid_q;

  sgc_cfg_regs #(.ADDR_W(2), .DATA_W(8)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  sgc_sync #(.N(N_SYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({clamp_pad_i, vsync_i, hflyback_i, hsync_i}),
    .sync_o (sync_s)
  );

  assign href_n      = (cfg.ref_sel ? sync_s[1] : sync_s[0]) ^ cfg.hpol;
  assign vs_n        = sync_s[2] ^ cfg.vpol;
  assign ext_clamp_n = sync_s[3] ^ cfg.clamp_pol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) href_q <= 1'b0;
    else         href_q <= href_n;
  end

  assign lead_edge = href_n & ~href_q;

  sgc_clamp_fsm #(.POS_W(CLAMP_POS_W), .PULSE_W(PULSE_W)) u_clamp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lead_edge_i (lead_edge),
    .pos_i       (cfg.clamp_pos),
    .pulse_o     (pulse)
  );

  always_comb begin
    if (cfg.blank_mode[1])      blank_act = href_n | vs_n;
    else if (cfg.blank_mode[0]) blank_act = vs_n;
    else                        blank_act = 1'b0;
  end

  assign blank_o        = blank_act ^ cfg.blank_pol;
  assign clamp_pad_oe_o = cfg.clamp_dir;
  assign clamp_pad_o    = pulse ^ cfg.clamp_pol;
  assign clamp_active_o = cfg.clamp_dir ? pulse : ext_clamp_n;

  assign vid_d = cfg.force_black ? BLACK_CODE : vid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vid_q <= '0;
    else         vid_q <= vid_d;
  end

  assign vid_o = vid_q;

  a_r11_black_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.force_black |=> (vid_o == BLACK_CODE));

  a_r5_blank_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.blank_mode == 2'b00) |-> (blank_o == cfg.blank_pol));

  a_r9_pad_follows_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_pad_oe_o |-> (clamp_pad_o == (clamp_active_o ^ cfg.clamp_pol)));

endmodule

// File: tb/sync_clamp_gen_test.sv
module sync_clamp_gen_test;

  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [7:0]  BLK = 8'h10;

  logic       clk, rst_n;
  logic       we;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic       hs, hf, vs, cpi;
  logic [7:0] vin;
  logic [7:0] vout;
  logic       blank, cpo, cpoe, cact;

  int checks, fails, cyc;
  bit done;

  // bench shadow of configuration bytes and sync pipelines
  logic [7:0] rg [4];
  logic s1h, s2h, s1f, s2f, s1v, s2v, s1c, s2c;
  logic nh_old, have_edge;
  int   last_edge, edge_pos;
  logic [7:0] vid_exp;

  sync_clamp_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .hsync_i(hs), .hflyback_i(hf), .vsync_i(vs),
    .clamp_pad_i(cpi), .vid_i(vin), .vid_o(vout), .blank_o(blank),
    .clamp_pad_o(cpo), .clamp_pad_oe_o(cpoe), .clamp_active_o(cact)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic f_blank(logic nh, logic nv, logic [7:0] r1);
    logic act;
    if (r1[1])      act = nh | nv;
    else if (r1[0]) act = nv;
    else            act = 1'b0;
    return act ^ r1[2];
  endfunction

  function automatic logic f_pulse(int n);
    int d;
    if (!have_edge) return 1'b0;
    d = n - last_edge - 1;
    return (d >= 2*edge_pos) && (d <= 2*edge_pos + 7);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    rg[0] = 8'h00; rg[1] = 8'h01; rg[2] = 8'h00; rg[3] = 8'h00;
    {s1h, s2h, s1f, s2f, s1v, s2v, s1c, s2c} = '0;
    nh_old = 1'b0; have_edge = 1'b0; last_edge = 0; edge_pos = 0;
    vid_exp = 8'h00;
  endtask

  task automatic tick(string ph);
    logic nh, nv, edge_now, pul, dir, cpol;
    @(posedge clk);
    cyc++;
    vid_exp = rg[0][3] ? BLK : vin;
    if (we) rg[addr] = wdata;
    s2h = s1h; s1h = hs; s2f = s1f; s1f = hf;
    s2v = s1v; s1v = vs; s2c = s1c; s1c = cpi;
    nh = (rg[0][2] ? s2f : s2h) ^ rg[0][0];
    nv = s2v ^ rg[0][1];
    edge_now = nh & ~nh_old;
    nh_old = nh;
    pul = f_pulse(cyc);
    if (edge_now) begin
      have_edge = 1'b1; last_edge = cyc; edge_pos = {rg[3][1:0], rg[2]};
    end
    dir = rg[1][3]; cpol = rg[1][4];
    @(negedge clk);
    chk({ph, " R11 vid"}, vout, vid_exp);
    chk({ph, " R5 blank"}, blank, f_blank(nh, nv, rg[1]));
    chk({ph, " R9 oe"}, cpoe, dir);
    chk({ph, " R7 pad"}, cpo, pul ^ cpol);
    chk({ph, " R10 active"}, cact, dir ? pul : (s2c ^ cpol));
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick("cfg");
    we = 1'b0;
  endtask

  task automatic run(string ph, int n, int hrate);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(hrate - 1) == 0) hs = ~hs;
      if ($urandom_range(hrate - 1) == 0) hf = ~hf;
      if ($urandom_range(15) == 0) vs = ~vs;
      if ($urandom_range(3) == 0) cpi = ~cpi;
      vin = 8'($urandom);
      tick(ph);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c1a3));
    checks = 0; fails = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    hs = 1'b0; hf = 1'b0; vs = 1'b0; cpi = 1'b0; vin = 8'h5a;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 blank", blank, 1'b0);
    chk("R1 oe", cpoe, 1'b0);
    chk("R1 pad", cpo, 1'b0);
    chk("R1 active", cact, 1'b0);
    chk("R1 vid", vout, 8'h00);
    rst_n = 1'b1;

    run("R1", 200, 12);         // defaults: vertical-only blank, input clamp
    wr(2'd1, 8'h00); run("R5 none", 200, 12);
    wr(2'd1, 8'h02); run("R5 full", 300, 12);
    wr(2'd1, 8'h06); run("R6", 300, 12);
    wr(2'd0, 8'h01); run("R2", 300, 12);
    wr(2'd0, 8'h02); run("R3", 300, 12);
    wr(2'd0, 8'h04); run("R4", 300, 12);
    wr(2'd0, 8'h05); run("R4 inv", 300, 12);

    // R9 / R7: clamp output mode over several positions
    wr(2'd1, 8'h0a); wr(2'd0, 8'h00);
    for (int k = 0; k < 6; k++) begin
      wr(2'd2, 8'($urandom_range(7)));
      run("R7", 400, 20);
    end
    wr(2'd1, 8'h1a); wr(2'd2, 8'h02); run("R9 inv", 400, 20);

    // R8: directed restart while delay runs (P=3 -> 6 cycle delay)
    wr(2'd1, 8'h0a); wr(2'd2, 8'h03); hs = 1'b0;
    repeat (12) tick("R8");
    hs = 1'b1; tick("R8"); hs = 1'b0; repeat (2) tick("R8");
    hs = 1'b1; tick("R8"); hs = 1'b0; repeat (20) tick("R8");
    run("R8", 600, 4);

    // R7 boundary: largest position, single edge
    wr(2'd2, 8'hff); wr(2'd3, 8'h03); hs = 1'b0;
    repeat (10) tick("R7 max");
    hs = 1'b1; repeat (2070) tick("R7 max"); hs = 1'b0;
    repeat (10) tick("R7 max");
    wr(2'd3, 8'h00);

    // R11: force black then release
    wr(2'd0, 8'h08); run("R11", 200, 12);
    wr(2'd0, 8'h00); run("R11 off", 100, 12);

    // R10: input clamp path, both polarities
    wr(2'd1, 8'h01); run("R10", 300, 12);
    wr(2'd1, 8'h11); run("R10 inv", 300, 12);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule